// File: doc/BRIEF.md
# Accumulator Register Unit with Carry

This block holds the working registers of a small nibble-wide processor: the accumulator A, the auxiliary register B, a double-width register E and the carry flag. Each clock cycle it takes one encoded command from the instruction decoder, along with a nibble read from data memory and a nibble immediate taken from the instruction word. It then updates its registers on the rising clock edge.

The commands are: add with carry, add the memory operand while keeping the carry, add the immediate while keeping the carry, rotate A right through the carry, set the carry, clear the carry, copy A into B, copy B into A, pack B:A into E and unpack E into B:A. All four registers are driven straight onto the outputs, so the surrounding datapath can see them the cycle after an update.

E has no reset. Its content is undefined until the first pack command writes it.

Top module: `acc_reg_unit`

## Requirements
- R1: Command code 1 (add with carry) writes the low nibble of A + operand + carry into A and writes the carry-out into the carry flag: 1 when the full sum exceeds 15, otherwise 0.
- R2: Command code 2 (add operand) writes (A + operand) mod 16 into A and leaves the carry flag unchanged.
- R3: Command code 3 (add immediate) writes (A + immediate) mod 16 into A and leaves the carry flag unchanged.
- R4: Command code 4 (rotate right through carry) moves bit 0 of A into the carry flag and sets A to {old carry, A[3:1]}.
- R5: Command code 5 forces the carry flag to 1, and command code 6 forces it to 0. Neither command changes A or B.
- R6: Command code 7 copies all of B into A. Command code 8 copies all of A into B.
- R7: Command code 9 (pack) loads E[7:4] from B and E[3:0] from A.
- R8: Command code 10 (unpack) loads B from E[7:4] and A from E[3:0].
- R9: Command code 0 and codes 11 to 15 leave A, B, E and the carry flag unchanged, whatever operand and immediate are applied.
- R10: While rst_n is low, A, B and the carry flag are held at 0. A command applied in the cycle before a rising edge becomes visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 4 | Encoded command for this cycle |
| mem_opnd | input | 4 | Nibble read from data memory |
| imm | input | 4 | Immediate nibble from the instruction |
| acc_a | output | 4 | Accumulator A |
| aux_b | output | 4 | Auxiliary register B |
| ext_e | output | 8 | Double-width register E |
| carry | output | 1 | Carry flag |

## Verification
Every result is due exactly one rising edge after its command, because each output comes straight from a register. The bench applies each command on a falling edge, waits for one rising edge and compares all outputs on the following falling edge against a reference model that it updates arithmetically. E is compared only after a pack has written it since the last reset, so its undefined initial value is never checked. Reset is checked on the falling edge after a rising edge taken with rst_n low.

// File: rtl/acc_pkg.sv
// Package for the accumulator register unit.
// Holds the command encoding and the internal select codes shared by the
// decoder, the carry control and the register bank.
package acc_pkg;

    // External command codes (4-bit). Codes 11..15 are treated as no-op.
    typedef enum logic [3:0] {
        CMD_NOP    = 4'd0,
        CMD_ADDC   = 4'd1,
        CMD_ADDM   = 4'd2,
        CMD_ADDI   = 4'd3,
        CMD_RORC   = 4'd4,
        CMD_SETC   = 4'd5,
        CMD_CLRC   = 4'd6,
        CMD_B2A    = 4'd7,
        CMD_A2B    = 4'd8,
        CMD_PACK   = 4'd9,
        CMD_UNPACK = 4'd10
    } cmd_e;

    // Source of the next accumulator value.
    typedef enum logic [2:0] {
        ASRC_HOLD,
        ASRC_SUM,
        ASRC_ROT,
        ASRC_FROM_B,
        ASRC_FROM_E
    } a_src_e;

    // Source of the next auxiliary value.
    typedef enum logic [1:0] {
        BSRC_HOLD,
        BSRC_FROM_A,
        BSRC_FROM_E
    } b_src_e;

    // Source of the next carry value.
    typedef enum logic [2:0] {
        CSRC_HOLD,
        CSRC_COUT,
        CSRC_A0,
        CSRC_ONE,
        CSRC_ZERO
    } c_src_e;

    // Decoded controls for one cycle.
    typedef struct packed {
        a_src_e a_src;
        b_src_e b_src;
        c_src_e c_src;
        logic   e_load;
        logic   use_imm;
        logic   use_cin;
    } ctl_t;

endpackage

// File: rtl/acc_cmd_decode.sv
// Command decoder.
// Turns the 4-bit command code into per-register select controls.
// Assumes one command per cycle. Unknown codes decode to "hold everything".
module acc_cmd_decode
    import acc_pkg::*;
(
    input  logic [3:0] cmd,
    output ctl_t       ctl
);

    // Map each command code onto its register selects.
    always_comb begin
        ctl = '{a_src: ASRC_HOLD, b_src: BSRC_HOLD, c_src: CSRC_HOLD,
                e_load: 1'b0, use_imm: 1'b0, use_cin: 1'b0};
        case (cmd_e'(cmd))
            CMD_ADDC: begin
                ctl.a_src   = ASRC_SUM;
                ctl.c_src   = CSRC_COUT;
                ctl.use_cin = 1'b1;
            end
            CMD_ADDM: ctl.a_src = ASRC_SUM;
            CMD_ADDI: begin
                ctl.a_src   = ASRC_SUM;
                ctl.use_imm = 1'b1;
            end
            CMD_RORC: begin
                ctl.a_src = ASRC_ROT;
                ctl.c_src = CSRC_A0;
            end
            CMD_SETC:   ctl.c_src = CSRC_ONE;
            CMD_CLRC:   ctl.c_src = CSRC_ZERO;
            CMD_B2A:    ctl.a_src = ASRC_FROM_B;
            CMD_A2B:    ctl.b_src = BSRC_FROM_A;
            CMD_PACK:   ctl.e_load = 1'b1;
            CMD_UNPACK: begin
                ctl.a_src = ASRC_FROM_E;
                ctl.b_src = BSRC_FROM_E;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_adder.sv
// Nibble adder with optional carry-in.
// Selects the memory operand or the immediate as the addend and returns the
// truncated sum and the carry-out. Purely combinational.
module acc_adder #(
    parameter int W = 4
) (
    input  logic         [W-1:0] a_in,
    input  logic         [W-1:0] mem_in,
    input  logic         [W-1:0] imm_in,
    input  logic                 cy_in,
    input  logic                 use_imm,
    input  logic                 use_cin,
    output logic         [W-1:0] sum,
    output logic                 cout
);

    localparam int SW = W + 1;

    logic [W-1:0]  addend;
    logic [SW-1:0] full;

    // Choose the addend and form the widened sum.
    always_comb begin
        addend = use_imm ? imm_in : mem_in;
        full   = {1'b0, a_in} + {1'b0, addend} + SW'(use_cin & cy_in);
        sum    = full[W-1:0];
        cout   = full[W];
    end

endmodule

// File: rtl/acc_carry_ctl.sv
// Carry flag control.
// Holds the carry register and picks its next value from the decoded source.
// Synchronous active-low reset clears the flag.
module acc_carry_ctl
    import acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  c_src_e c_src,
    input  logic   add_cout,
    input  logic   a_lsb,
    output logic   cy
);

    logic cy_nxt;

    // Select the next carry value.
    always_comb begin
        case (c_src)
            CSRC_COUT: cy_nxt = add_cout;
            CSRC_A0:   cy_nxt = a_lsb;
            CSRC_ONE:  cy_nxt = 1'b1;
            CSRC_ZERO: cy_nxt = 1'b0;
            default:   cy_nxt = cy;
        endcase
    end

    // Register the carry with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cy <= 1'b0;
        else        cy <= cy_nxt;
    end

endmodule

// File: rtl/acc_regs.sv
// Register bank for A, B and E.
// A and B reset to zero. E has no reset and is undefined until the first pack.
// E is split into W-bit slices by a generate loop, slice 1 belonging to B.
module acc_regs
    import acc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  a_src_e         a_src,
    input  b_src_e         b_src,
    input  logic           e_load,
    input  logic [W-1:0]   sum,
    input  logic           cy,
    output logic [W-1:0]   a_q,
    output logic [W-1:0]   b_q,
    output logic [2*W-1:0] e_q
);

    localparam int NSLICE = 2;

    logic [W-1:0] a_nxt;
    logic [W-1:0] b_nxt;
    logic [W-1:0] pair [NSLICE];

    assign pair[0] = a_q;
    assign pair[1] = b_q;

    // Next accumulator value.
    always_comb begin
        case (a_src)
            ASRC_SUM:    a_nxt = sum;
            ASRC_ROT:    a_nxt = {cy, a_q[W-1:1]};
            ASRC_FROM_B: a_nxt = b_q;
            ASRC_FROM_E: a_nxt = e_q[W-1:0];
            default:     a_nxt = a_q;
        endcase
    end

    // Next auxiliary value.
    always_comb begin
        case (b_src)
            BSRC_FROM_A: b_nxt = a_q;
            BSRC_FROM_E: b_nxt = e_q[2*W-1:W];
            default:     b_nxt = b_q;
        endcase
    end

    // Register A and B with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a_nxt;
            b_q <= b_nxt;
        end
    end

    // E slices load from the B:A pair on pack; no reset by design.
    for (genvar gs = 0; gs < NSLICE; gs++) begin : g_eslice
        always_ff @(posedge clk) begin
            if (e_load) e_q[gs*W +: W] <= pair[gs];
        end
    end

endmodule

// File: rtl/acc_reg_unit.sv
// Accumulator register unit (top).
// Executes one decoded command per cycle on A, B, E and the carry flag.
// Every output comes straight from a register, so results appear one edge later.
module acc_reg_unit
    import acc_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         cmd,
    input  logic [NIB_W-1:0]   mem_opnd,
    input  logic [NIB_W-1:0]   imm,
    output logic [NIB_W-1:0]   acc_a,
    output logic [NIB_W-1:0]   aux_b,
    output logic [2*NIB_W-1:0] ext_e,
    output logic               carry
);

    ctl_t             ctl;
    logic [NIB_W-1:0] sum;
    logic             cout;

    acc_cmd_decode u_dec (
        .cmd (cmd),
        .ctl (ctl)
    );

    acc_adder #(.W(NIB_W)) u_add (
        .a_in    (acc_a),
        .mem_in  (mem_opnd),
        .imm_in  (imm),
        .cy_in   (carry),
        .use_imm (ctl.use_imm),
        .use_cin (ctl.use_cin),
        .sum     (sum),
        .cout    (cout)
    );

    acc_carry_ctl u_cy (
        .clk      (clk),
        .rst_n    (rst_n),
        .c_src    (ctl.c_src),
        .add_cout (cout),
        .a_lsb    (acc_a[0]),
        .cy       (carry)
    );

    acc_regs #(.W(NIB_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_src  (ctl.a_src),
        .b_src  (ctl.b_src),
        .e_load (ctl.e_load),
        .sum    (sum),
        .cy     (carry),
        .a_q    (acc_a),
        .b_q    (aux_b),
        .e_q    (ext_e)
    );

endmodule

// File: rtl/acc_reg_unit_chk.sv
// Assertion checker for acc_reg_unit, attached by bind.
// Relates each command to the register values one edge later.
module acc_reg_unit_chk #(
    parameter int NIB_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         cmd,
    input logic [NIB_W-1:0]   mem_opnd,
    input logic [NIB_W-1:0]   imm,
    input logic [NIB_W-1:0]   acc_a,
    input logic [NIB_W-1:0]   aux_b,
    input logic [2*NIB_W-1:0] ext_e,
    input logic               carry
);

    localparam int SW = NIB_W + 1;

    AST_ADDC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd1) |=> ({carry, acc_a} == (SW'($past(acc_a)) + SW'($past(mem_opnd)) + SW'($past(carry))))); // R1

    AST_ADDM_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd2) |=> (carry == $past(carry) && acc_a == NIB_W'($past(acc_a) + $past(mem_opnd)))); // R2

    AST_ADDI_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd3) |=> (carry == $past(carry) && acc_a == NIB_W'($past(acc_a) + $past(imm)))); // R3

    AST_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd4) |=> (carry == $past(acc_a[0]) && acc_a == {$past(carry), $past(acc_a[NIB_W-1:1])})); // R4

    AST_SET_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd5) |=> (carry && $stable(acc_a) && $stable(aux_b))); // R5

    AST_CLEAR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd6) |=> (!carry && $stable(acc_a) && $stable(aux_b))); // R5

    AST_COPY_B2A: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd7) |=> (acc_a == $past(aux_b))); // R6

    AST_COPY_A2B: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd8) |=> (aux_b == $past(acc_a))); // R6

    AST_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd9) |=> (ext_e == {$past(aux_b), $past(acc_a)})); // R7

    AST_UNPACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd10) |=> ({aux_b, acc_a} == $past(ext_e))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'd0 || cmd > 4'd10) |=> ($stable(acc_a) && $stable(aux_b) && $stable(carry))); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_a == '0 && aux_b == '0 && !carry)); // R10

endmodule

bind acc_reg_unit acc_reg_unit_chk #(.NIB_W(NIB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .mem_opnd (mem_opnd),
    .imm      (imm),
    .acc_a    (acc_a),
    .aux_b    (aux_b),
    .ext_e    (ext_e),
    .carry    (carry)
);

// File: tb/acc_reg_unit_test.sv
// Self-checking bench for acc_reg_unit: arithmetic reference model and sweeps.
module acc_reg_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = 4'd0;
    logic [3:0] mem_opnd = 4'd0;
    logic [3:0] imm = 4'd0;
    logic [3:0] acc_a;
    logic [3:0] aux_b;
    logic [7:0] ext_e;
    logic       carry;

    int n_run  = 0;
    int n_fail = 0;
    int m_a = 0, m_b = 0, m_e = 0, m_cy = 0;
    bit e_valid = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acc_reg_unit uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .mem_opnd(mem_opnd), .imm(imm),
        .acc_a(acc_a), .aux_b(aux_b), .ext_e(ext_e), .carry(carry)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "A", int'(acc_a), m_a);
        chk(tag, "B", int'(aux_b), m_b);
        chk(tag, "CY", int'(carry), m_cy);
        if (e_valid) chk(tag, "E", int'(ext_e), m_e);
    endtask

    // Apply one command at a falling edge, update the model, compare one edge later.
    task automatic step(input int op, input int m, input int i, input string tag);
        int s, na;
        cmd = 4'(op); mem_opnd = 4'(m); imm = 4'(i);
        case (op)
            1: begin s = m_a + m + m_cy; m_a = s & 15; m_cy = s >> 4; end
            2: m_a = (m_a + m) & 15;
            3: m_a = (m_a + i) & 15;
            4: begin na = (m_cy << 3) | (m_a >> 1); m_cy = m_a & 1; m_a = na; end
            5: m_cy = 1;
            6: m_cy = 0;
            7: m_a = m_b;
            8: m_b = m_a;
            9: begin m_e = (m_b << 4) | m_a; e_valid = 1; end
            10: begin m_b = m_e >> 4; m_a = m_e & 15; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic set_a(input int v);
        step(3, int'($urandom_range(15)), (v - m_a) & 15, "R3");
    endtask

    task automatic set_b(input int v);
        set_a(v);
        step(8, 0, 0, "R6");
    endtask

    task automatic set_cy(input int v);
        step(v ? 5 : 6, int'($urandom_range(15)), int'($urandom_range(15)), "R5");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10: reset state.
        @(negedge clk); @(negedge clk);
        chk("R10", "A", int'(acc_a), 0);
        chk("R10", "B", int'(aux_b), 0);
        chk("R10", "CY", int'(carry), 0);
        rst_n = 1'b1;

        // R1: add with carry, every A, operand and carry-in.
        for (int a = 0; a < 16; a++)
            for (int m = 0; m < 16; m++)
                for (int c = 0; c < 2; c++) begin
                    set_a(a); set_cy(c);
                    step(1, m, int'($urandom_range(15)), "R1");
                end

        // R2: add operand keeps the carry.
        for (int a = 0; a < 16; a++)
            for (int m = 0; m < 16; m++) begin
                set_a(a); set_cy((a + m) & 1);
                step(2, m, int'($urandom_range(15)), "R2");
            end

        // R3: add immediate keeps the carry.
        for (int a = 0; a < 16; a++)
            for (int i = 0; i < 16; i++) begin
                set_a(a); set_cy((a ^ i) & 1);
                step(3, int'($urandom_range(15)), i, "R3");
            end

        // R4: rotate right through carry.
        for (int a = 0; a < 16; a++)
            for (int c = 0; c < 2; c++) begin
                set_a(a); set_cy(c);
                step(4, 0, 0, "R4");
                step(4, 0, 0, "R4");
            end

        // R5: set and clear carry from both prior states.
        for (int k = 0; k < 4; k++) begin
            set_a(k * 5); set_b(k * 3);
            step(5, 15, 15, "R5"); step(5, 0, 0, "R5");
            step(6, 15, 15, "R5"); step(6, 0, 0, "R5");
        end

        // R6: full-nibble copies in both directions.
        for (int v = 0; v < 16; v++) begin
            set_a(v); step(8, 0, 0, "R6");
            set_a(~v & 15); step(7, 0, 0, "R6");
        end

        // R7 and R8: pack and unpack over every B:A pair.
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                set_b(b); set_a(a);
                step(9, 0, 0, "R7");
                set_a((a + 7) & 15); step(8, 0, 0, "R6"); set_a((a + 3) & 15);
                step(10, 0, 0, "R8");
            end

        // R9: no-op codes ignore operands.
        set_a(9); set_b(6); set_cy(1); step(9, 0, 0, "R7"); set_a(12);
        for (int op = 0; op < 16; op++)
            if (op == 0 || op > 10)
                for (int r = 0; r < 4; r++)
                    step(op, int'($urandom_range(15)), int'($urandom_range(15)), "R9");

        // R10: mid-run reset clears A, B, CY.
        set_a(13); set_b(11); set_cy(1);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        m_a = 0; m_b = 0; m_cy = 0; e_valid = 0;
        check_all("R10");
        rst_n = 1'b1;
        step(1, 15, 0, "R10");

        finish_run();
    end

endmodule